// File: doc/BRIEF.md
# Smart Card Reset Sequencer with Answer Timing

This block drives the reset line of an ISO 7816 style card and measures, in card clock cycles, how long the card takes to answer. Software sets a 16-bit reset-low duration and then raises a start bit. The block pulls the card reset line low for that many card clock cycles and then releases it. The first operation after power-up is a cold activation: the line is already low and is released when the count runs out. A later start is a warm reset: the line goes from high to low and is released the same way.

Once reset is released, a 16-bit up-counter runs on the card clock enable. The first falling edge on the card I/O line, taken through a two-flop synchronizer, is the answer. The counter value at that moment is latched into a capture register. The latched value is then sorted into one of three results: answered on time, answered too early, or answered late. If the counter reaches its top value with no answer, the sequence ends as "no answer".

A byte-wide register port gives access to the timer value, the start bit, the status flags and both capture bytes. All timing advances only on cycles where the card clock enable is high.

Top module: `scr_rst_timer`

## Requirements
- R1: After `rst_ni` is asserted, `card_rst_o` and `busy_o` are low and the status register (address 3) reads 0. The timer reads 400: address 0 gives 0x90 and address 1 gives 0x01. Both capture bytes read 0.
- R2: After a start, `card_rst_o` stays low for exactly TIMER card-clock-enable cycles and then goes high. A timer value of 0 acts as 1. The timer low byte is at address 0 and the high byte is at address 1.
- R3: A start happens only when bit 0 of the control register (address 2) is written as 1 while its stored value is 0. Writing 1 while it already holds 1 starts nothing.
- R4: From the release of reset, a 16-bit counter advances once per card clock enable. The I/O line passes through two synchronizer flops. With the enable held high, a falling edge applied K cycles after release captures K+2. The capture low byte is at address 4 and the high byte is at address 5.
- R5: A capture from 400 to 40000 inclusive gives status 0x01 (bit 0, done).
- R6: A capture below 400 gives status 0x03 (done plus bit 1, too early).
- R7: A capture above 40000 gives status 0x05 (done plus bit 2, late).
- R8: If the counter is at 65535 on an enable cycle and no answer has arrived, the capture is 0xFFFF and the status is 0x09 (done plus bit 3, no answer). Reset stays released.
- R9: `busy_o` and status bit 4 are high from the start until the capture or the overflow. Start requests made while busy are ignored.
- R10: All result flags clear when a new sequence starts.
- R11: Falling edges on the I/O line while reset is held low are ignored. Only the first falling edge after release is captured, and later edges leave the capture unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cclk_en_i | input | 1 | One-cycle pulse per card clock period |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| card_io_i | input | 1 | Card I/O line, asynchronous |
| card_rst_o | output | 1 | Card reset line |
| busy_o | output | 1 | Sequence in progress |

## Verification
The hardest cases to reach are the window edges and the counter overflow. Both need the answer edge placed to the exact card cycle, tens of thousands of cycles after release. The bench holds the enable high and counts cycles from the observed rise of `card_rst_o`. It drops the I/O line so that the captures land on 399, 400, 40000 and 40001, and it runs one sequence with no answer until the counter wraps. Two further cases are set up from the ports while a sequence is running:
- A restart attempted during the wait phase.
- An I/O glitch while reset is held low.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_WAIT
  } scr_state_e;

  typedef struct packed {
    logic busy;
    logic no_atr;
    logic late;
    logic early;
    logic done;
  } scr_status_t;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_TIM_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_TIM_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd5;
endpackage

// File: rtl/scr_io_sync.sv
module scr_io_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic io_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // line idles high, so reset to 1 to avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], io_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/scr_regs.sv
module scr_regs
  import scr_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned TIMER_RST = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  scr_status_t       status_i,
  input  logic [CNT_W-1:0]  capture_i,
  output logic [CNT_W-1:0]  timer_o,
  output logic              start_o
);
  localparam int unsigned HI_W = CNT_W - 8;

  logic [CNT_W-1:0] timer_q;
  logic             ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= CNT_W'(TIMER_RST);
      ctrl_q  <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        A_TIM_LO: timer_q[7:0]       <= wdata_i;
        A_TIM_HI: timer_q[CNT_W-1:8] <= wdata_i[HI_W-1:0];
        A_CTRL:   ctrl_q             <= wdata_i[0];
        default: ;
      endcase
    end
  end

  // rising edge of the stored start bit only
  assign start_o = we_i && (addr_i == A_CTRL) && wdata_i[0] && !ctrl_q;
  assign timer_o = timer_q;

  always_comb begin
    unique case (addr_i)
      A_TIM_LO: rdata_o = timer_q[7:0];
      A_TIM_HI: rdata_o = 8'(timer_q[CNT_W-1:8]);
      A_CTRL:   rdata_o = {7'd0, ctrl_q};
      A_STAT:   rdata_o = {3'd0, status_i};
      A_CAP_LO: rdata_o = capture_i[7:0];
      A_CAP_HI: rdata_o = 8'(capture_i[CNT_W-1:8]);
      default:  rdata_o = 8'd0;
    endcase
  end

  assert_start_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> ctrl_q);
endmodule

// File: rtl/scr_seq.sv
module scr_seq
  import scr_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ATR_MIN = 400,
  parameter int unsigned ATR_MAX = 40000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cclk_en_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] timer_i,
  input  logic             fall_i,
  output logic             card_rst_o,
  output scr_status_t      status_o,
  output logic [CNT_W-1:0] capture_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] LIM_LO  = CNT_W'(ATR_MIN);
  localparam logic [CNT_W-1:0] LIM_HI  = CNT_W'(ATR_MAX);

  scr_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, capture_q;
  logic             card_rst_q, done_q, early_q, late_q, noatr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      capture_q  <= '0;
      card_rst_q <= 1'b0;
      done_q     <= 1'b0;
      early_q    <= 1'b0;
      late_q     <= 1'b0;
      noatr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q    <= ST_RST_LOW;
          cnt_q      <= timer_i;
          card_rst_q <= 1'b0;
          done_q     <= 1'b0;
          early_q    <= 1'b0;
          late_q     <= 1'b0;
          noatr_q    <= 1'b0;
        end
        ST_RST_LOW: if (cclk_en_i) begin
          if (cnt_q <= CNT_W'(1)) begin
            cnt_q      <= '0;
            card_rst_q <= 1'b1;
            state_q    <= ST_WAIT;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WAIT: begin
          if (fall_i) begin
            capture_q <= cnt_q;
            done_q    <= 1'b1;
            early_q   <= cnt_q < LIM_LO;
            late_q    <= cnt_q > LIM_HI;
            state_q   <= ST_IDLE;
          end else if (cclk_en_i) begin
            if (cnt_q == CNT_TOP) begin
              capture_q <= cnt_q;
              done_q    <= 1'b1;
              noatr_q   <= 1'b1;
              state_q   <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign card_rst_o = card_rst_q;
  assign capture_o  = capture_q;
  assign status_o   = '{busy: state_q != ST_IDLE, no_atr: noatr_q, late: late_q,
                        early: early_q, done: done_q};

  assert_release_from_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_rst_q) |-> $past(state_q == ST_RST_LOW));

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && $past(state_q == ST_WAIT) && $past(cclk_en_i))
      |-> (cnt_q - $past(cnt_q)) == CNT_W'(1));

  assert_one_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({early_q, late_q, noatr_q}));

  assert_capture_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q == ST_IDLE)) |-> $stable(capture_q));

  assert_no_restart_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q == ST_WAIT) && $past(start_i)) |-> state_q != ST_RST_LOW);

  assert_done_ends_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> state_q == ST_IDLE);
endmodule

// File: rtl/scr_rst_timer.sv
module scr_rst_timer
  import scr_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned TIMER_RST   = 400,
  parameter int unsigned ATR_MIN     = 400,
  parameter int unsigned ATR_MAX     = 40000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cclk_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              card_io_i,
  output logic              card_rst_o,
  output logic              busy_o
);
  logic [CNT_W-1:0] timer, capture;
  logic             start, io_fall;
  scr_status_t      status;

  scr_io_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .io_i   (card_io_i),
    .fall_o (io_fall)
  );

  scr_regs #(.CNT_W(CNT_W), .TIMER_RST(TIMER_RST)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .status_i  (status),
    .capture_i (capture),
    .timer_o   (timer),
    .start_o   (start)
  );

  scr_seq #(.CNT_W(CNT_W), .ATR_MIN(ATR_MIN), .ATR_MAX(ATR_MAX)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cclk_en_i  (cclk_en_i),
    .start_i    (start),
    .timer_i    (timer),
    .fall_i     (io_fall),
    .card_rst_o (card_rst_o),
    .status_o   (status),
    .capture_o  (capture)
  );

  assign busy_o = status.busy;
endmodule

// File: tb/scr_rst_timer_tb_top.sv
module scr_rst_timer_tb_top;
  typedef struct {
    int low;
    int cap;
    int stat;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cclk_en = 1'b1;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       io = 1'b1;
  logic       card_rst, busy;

  int checks = 0, fails = 0, mon_cnt = 0, low_cnt = 0;
  bit done_all = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  scr_rst_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cclk_en_i(cclk_en), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .card_io_i(io), .card_rst_o(card_rst), .busy_o(busy)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    addr = a;
    #1 d = int'(rdata);
  endtask

  function automatic int stat_of(int cap, bit ovf);
    if (ovf) return 9;
    if (cap < 400) return 3;
    if (cap > 40000) return 5;
    return 1;
  endfunction

  // driver: program, start, push expectation, place the answer edge
  task automatic run_seq(int tmr, int k, bit glitch, bit busy_start);
    exp_t e;
    int target, v;
    e.low = (tmr == 0) ? 1 : tmr;
    e.cap = (k < 0) ? 65535 : k + 2;
    e.stat = stat_of(e.cap, k < 0);
    exp_q.push_back(e);
    target = mon_cnt + 1;
    wr(3'd0, 8'(tmr));
    wr(3'd1, 8'(tmr >> 8));
    wr(3'd2, 8'd0);
    wr(3'd2, 8'd1);
    rd(3'd3, v);
    if (tmr >= 3) check("R10 flags cleared on start", v, 16);
    if (glitch) begin
      io = 1'b0;
      repeat (3) @(negedge clk);
      io = 1'b1;
    end
    while (!card_rst) @(negedge clk);
    if (k >= 0) begin
      if (busy_start) begin
        wr(3'd2, 8'd0);
        wr(3'd2, 8'd1);
        check("R9 start ignored while busy", int'(card_rst), 1);
        check("R9 busy during wait", int'(busy), 1);
        repeat (k - 4) @(negedge clk);
      end else begin
        repeat (k) @(negedge clk);
      end
      io = 1'b0;
    end
    wait (mon_cnt == target);
    @(negedge clk);
    io = 1'b1;
  endtask

  // monitor: measure reset-low time, compare results when busy drops
  initial begin
    bit prev_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (busy && !prev_busy) low_cnt = 0;
      if (busy && !card_rst) low_cnt++;
      if (prev_busy && !busy) begin
        exp_t e;
        int lo, hi, st;
        e = exp_q.pop_front();
        check("R2 reset low cycles", low_cnt, e.low);
        rd(3'd4, lo);
        rd(3'd5, hi);
        check("R4 capture value", hi * 256 + lo, e.cap);
        rd(3'd3, st);
        check("R5/R6/R7/R8 status", st, e.stat);
        mon_cnt++;
      end
      prev_busy = busy;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 card reset low", int'(card_rst), 0);
    check("R1 busy low", int'(busy), 0);
    rd(3'd0, v); check("R1 timer lsb", v, 8'h90);
    rd(3'd1, v); check("R1 timer msb", v, 8'h01);
    rd(3'd3, v); check("R1 status", v, 0);
    rd(3'd4, v); check("R1 capture lsb", v, 0);
    rd(3'd5, v); check("R1 capture msb", v, 0);
    // R2 R5 cold activation with default length, capture exactly 400
    run_seq(400, 398, 1'b0, 1'b0);
    // R6 capture 399
    run_seq(3, 397, 1'b0, 1'b0);
    // R2 timer zero acts as one
    run_seq(0, 0, 1'b0, 1'b0);
    // R11 glitch during reset low ignored
    run_seq(20, 10, 1'b1, 1'b0);
    io = 1'b0;
    repeat (4) @(negedge clk);
    io = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd4, v); check("R11 later edge ignored", v, 12);
    // R3 writing 1 over stored 1 starts nothing
    wr(3'd2, 8'd1);
    repeat (3) @(negedge clk);
    check("R3 no start busy", int'(busy), 0);
    check("R3 no start reset", int'(card_rst), 1);
    rd(3'd3, v); check("R3 status unchanged", v, 3);
    // R5 R9 upper window edge with restart attempt
    run_seq(2, 39998, 1'b0, 1'b1);
    // R7 late
    run_seq(2, 39999, 1'b0, 1'b0);
    // R8 no answer
    run_seq(2, -1, 1'b0, 1'b0);
    check("R8 reset stays released", int'(card_rst), 1);
    done_all = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done_all && n < 195000) begin
      @(posedge clk);
      n++;
    end
    if (!done_all) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", n);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule